// File: doc/BRIEF.md
# Four-Slot One-Time-Programmable Setting Store

This block holds a 10-bit output setting in a store that can be programmed at most four times. Each slot is written only once. A program request burns its value into the next free slot after a fixed busy period. From then on the newest written slot is the value the store gives back. The live output code follows each successful program operation. It can also be reloaded from the store on request.

Two reload requests differ in what they give when no slot has been written. The reset-style reload falls back to mid-scale. The acquire request falls back to zero. A thermometer status code reports how many slots are used. When all four slots are used, further program requests are refused and a one-cycle reject pulse is raised.

Top module: `otp_slot_store`

## Requirements
- R1: A program request accepted while idle and not full raises busy in the next cycle and holds it for BURN_CYCLES cycles. It then writes the value into the next free slot, drops busy and pulses done for exactly one cycle.
- R2: The status code is 4'b0000 with no slot written. It is 4'b0001, 4'b0011, 4'b0111 and 4'b1111 after one, two, three and four writes: bit i is set when slot i is written.
- R3: Once all four slots are written, a further program request changes neither the status nor the output code, and busy stays low.
- R4: A program request arriving while the store is full and idle gives a reject pulse of one cycle in the following cycle. No other request produces a reject pulse.
- R5: After rst_n is released the store is empty, the status is 4'b0000, busy is low, and the output code is mid-scale 10'b1000000000.
- R6: A reload request loads the newest written slot into the output code, or mid-scale 10'b1000000000 when no slot is written.
- R7: An acquire request loads the newest written slot into the output code, or 10'b0000000000 when no slot is written.
- R8: When a program operation completes, the output code becomes the newly written value in the same cycle that done is high.
- R9: While busy, program, acquire and reload requests are all ignored. The output code holds until completion, and only one slot is consumed.
- R10: When requests coincide in one idle cycle, program is served first, reload second and acquire last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties the store |
| prog_req | input | 1 | Program strobe, one cycle |
| prog_data | input | 10 | Value to burn |
| acq_req | input | 1 | Acquire request (zero fallback) |
| reload_req | input | 1 | Reset-style reload request (mid-scale fallback) |
| code_out | output | 10 | Live output code |
| status | output | 4 | Thermometer programming status |
| busy | output | 1 | Burn in progress |
| done | output | 1 | One-cycle pulse when a burn completes |
| reject | output | 1 | One-cycle pulse for a program request while full |

## Verification
The assertions assume that request strobes last a single cycle. In particular, the rule that a reject pulse is followed by a low cycle needs prog_req to be dropped after one cycle. The bench drives every strobe for exactly one clock and waits at least one cycle between requests. It issues requests during busy only to show that they are ignored. Under these conditions the thermometer shape, the frozen full state and the held code during a burn hold for every pattern the bench applies.

// File: rtl/otp_slot_store.sv
module otp_slot_store #(
  parameter int DW = 10,
  parameter int SLOTS = 4,
  parameter int BURN_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_req,
  input  logic [DW-1:0] prog_data,
  input  logic          acq_req,
  input  logic          reload_req,
  output logic [DW-1:0] code_out,
  output logic [SLOTS-1:0] status,
  output logic          busy,
  output logic          done,
  output logic          reject
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW = $clog2(BURN_CYCLES + 1);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] written_q;
  logic [DW-1:0]    pend_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    top_idx, next_idx;
  logic             any_w, full;
  logic [DW-1:0]    latest;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (written_q[i]) top_idx = IW'(i);
  end

  assign any_w    = |written_q;
  assign full     = &written_q;
  assign next_idx = any_w ? IW'(top_idx + 1'b1) : '0;
  assign latest   = any_w ? slot_q[top_idx] : '0;
  assign status   = written_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
      written_q <= '0;
      pend_q    <= '0;
      cnt_q     <= '0;
      code_out  <= MID;
      busy      <= 1'b0;
      done      <= 1'b0;
      reject    <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= 1'b0;
      if (busy) begin
        if (cnt_q == '0) begin
          slot_q[next_idx]    <= pend_q;
          written_q[next_idx] <= 1'b1;
          code_out            <= pend_q;
          busy                <= 1'b0;
          done                <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (prog_req) begin
        if (full) begin
          reject <= 1'b1;
        end else begin
          busy   <= 1'b1;
          cnt_q  <= CW'(BURN_CYCLES - 1);
          pend_q <= prog_data;
        end
      end else if (reload_req) begin
        code_out <= any_w ? latest : MID;
      end else if (acq_req) begin
        code_out <= latest;
      end
    end
  end
endmodule

module otp_slot_store_chk #(
  parameter int DW = 10,
  parameter int SLOTS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_req,
  input logic [DW-1:0]    code_out,
  input logic [SLOTS-1:0] status,
  input logic             busy,
  input logic             done,
  input logic             reject
);
  AST_STATUS_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status + 1'b1) & status) == '0); // R2
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (&status) |=> ((&status) && !busy)); // R3
  AST_REJECT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> ((&status) && $past(prog_req))); // R4
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != $past(status))); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(code_out) || done)); // R9
endmodule

bind otp_slot_store otp_slot_store_chk #(.DW(DW), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .code_out(code_out),
  .status(status), .busy(busy), .done(done), .reject(reject));

// File: tb/sim_otp_slot_store.sv
`timescale 1ns/1ps
module sim_otp_slot_store;
  localparam int DW = 10;
  localparam int SLOTS = 4;
  localparam int BURN = 8;
  localparam logic [DW-1:0] MID = 10'b1000000000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_req = 0, acq_req = 0, reload_req = 0;
  logic [DW-1:0] prog_data = '0;
  logic [DW-1:0] code_out;
  logic [SLOTS-1:0] status;
  logic busy, done, reject;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  otp_slot_store #(.DW(DW), .SLOTS(SLOTS), .BURN_CYCLES(BURN)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_data(prog_data),
    .acq_req(acq_req), .reload_req(reload_req), .code_out(code_out),
    .status(status), .busy(busy), .done(done), .reject(reject));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SLOTS-1:0] thermo(int n);
    return SLOTS'((1 << n) - 1);
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
    step();
  endtask

  task automatic pulse_prog(logic [DW-1:0] v);
    prog_data = v; prog_req = 1; step(); prog_req = 0;
  endtask

  task automatic pulse_acq();
    acq_req = 1; step(); acq_req = 0;
  endtask

  task automatic pulse_reload();
    reload_req = 1; step(); reload_req = 0;
  endtask

  task automatic full_prog(logic [DW-1:0] v, int used, logic [DW-1:0] prev);
    pulse_prog(v);
    chk("R1 busy rises", busy, 1);
    repeat (BURN - 1) step();
    chk("R1 busy held", busy, 1);
    chk("R9 code held during burn", code_out, prev);
    step();
    chk("R1 busy falls", busy, 0);
    chk("R1 done pulse", done, 1);
    chk("R8 code updated", code_out, v);
    chk("R2 status", status, thermo(used + 1));
    step();
    chk("R1 done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] vals [SLOTS];
    logic [DW-1:0] last;
    do_reset();
    chk("R5 code midscale", code_out, MID);
    chk("R5 status empty", status, 0);
    chk("R5 busy low", busy, 0);
    pulse_acq();
    chk("R7 acquire empty gives zero", code_out, 0);
    pulse_reload();
    chk("R6 reload empty gives midscale", code_out, MID);
    acq_req = 1; reload_req = 1; step(); acq_req = 0; reload_req = 0;
    chk("R10 reload beats acquire", code_out, MID);

    for (int r = 0; r < 6; r++) begin
      do_reset();
      chk("R5 status after reset", status, 0);
      last = MID;
      for (int k = 0; k < SLOTS; k++) begin
        vals[k] = DW'((r * 137 + k * 301 + 5) % 1024);
        if (r == 1 && k == 0) vals[k] = '0;
        if (r == 2 && k == 3) vals[k] = 10'h3FF;
        full_prog(vals[k], k, last);
        last = vals[k];
        pulse_acq();
        pulse_acq();
        chk("R7 acquire gives newest slot", code_out, vals[k]);
        pulse_reload();
        chk("R6 reload gives newest slot", code_out, vals[k]);
      end
      pulse_prog(10'h155);
      chk("R4 reject pulse", reject, 1);
      chk("R3 busy stays low", busy, 0);
      step();
      chk("R4 reject one cycle", reject, 0);
      chk("R3 status frozen", status, 4'b1111);
      chk("R3 code unchanged", code_out, vals[SLOTS-1]);
      pulse_acq();
      chk("R4 no reject on acquire", reject, 0);
      chk("R3 acquire keeps last write", code_out, vals[SLOTS-1]);
    end

    do_reset();
    pulse_prog(10'd100);
    step();
    pulse_acq();
    chk("R9 acquire ignored while busy", code_out, MID);
    pulse_prog(10'd200);
    pulse_reload();
    chk("R9 reload ignored while busy", code_out, MID);
    repeat (BURN) step();
    chk("R9 one slot consumed", status, 4'b0001);
    chk("R9 first value kept", code_out, 100);
    pulse_acq();
    chk("R9 stored value is first", code_out, 100);

    prog_data = 10'd300; prog_req = 1; acq_req = 1; reload_req = 1;
    step();
    prog_req = 0; acq_req = 0; reload_req = 0;
    chk("R10 program wins", busy, 1);
    repeat (BURN) step();
    chk("R10 program value stored", code_out, 300);
    chk("R10 status two", status, 4'b0011);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule